// File: doc/BRIEF.md
# Floppy Controller Host I/O Register Interface

This block sits between an 8-bit host processor's I/O bus and a single-chip floppy disk controller that expects its data lines in inverted polarity. It decodes the host's I/O strobes, selects the controller for its four-port register window, and flips every data bit in both directions so that the controller's inverted bus looks normal to the host.

Besides the data path, it holds the small amount of drive-side state the controller itself does not keep. This state is a drive/motor register that uses an offset drive code, a head-side bit, a density bit and an interrupt-enable bit. The interrupt-enable bit is armed by a write to its port and disarmed by a read of the same port. The block also captures the host-type jumpers while reset is held so that firmware can read them back, and it halves its input clock to run the controller. All host-bus timing is taken on the rising edge of the block clock.

Top module: `fdc_io_regs`

## Requirements
- R1: `fdc_cs_n_o` is low exactly when `iorq_n_i` is low, `rd_n_i` or `wr_n_i` is low, and `addr_i` is in 0xD8–0xDB.
- R2: During an I/O write to 0xD8–0xDB, `fdata_o` equals the bitwise inverse of `hdata_i`.
- R3: During an I/O read of 0xD8–0xDB, `hdata_o` equals the bitwise inverse of `fdata_i`, and `hdata_oe_o` is high.
- R4: An I/O write to 0xDC stores bits [2:0] as a drive code and bit 7 as the motor enable. Codes 4, 5, 6 and 7 drive `drv_sel_n_o` bit 0, 1, 2 or 3 low (all others high). Codes 0–3 leave all four high. `motor_o` follows bit 7.
- R5: An I/O write to 0xDD sets `side_o` to 1 when data bit 0 is 0 and to 0 when data bit 0 is 1.
- R6: An I/O write to 0xDE sets `dden_n_o` to the value of data bit 0, so 0 selects double density.
- R7: An I/O write to 0xDF sets the interrupt enable and an I/O read of 0xDF clears it. `int_o` equals `intrq_i` AND the enable.
- R8: `mode_i` is sampled on every clock while `rst_n_i` is low, and the value held at reset release is kept. An I/O read of 0x63 returns it in bits [2:0] with bits [7:3] zero.
- R9: `fdc_clk_o` is 0 in reset and toggles on every clock edge after reset release, which gives half the input frequency.
- R10: After reset, `drv_sel_n_o` is 4'b1111, `motor_o` is 0, `side_o` is 0, `dden_n_o` is 1 and the interrupt enable is clear.
- R11: `hdata_oe_o` is high only during an I/O read of 0xD8–0xDB or 0x63. Reads of 0xDC–0xDF leave it low.
- R12: `fdata_oe_o` is high only during an I/O write to 0xD8–0xDB, and never at the same time as `hdata_oe_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock (nominally 16 MHz) |
| rst_n_i | input | 1 | Synchronous active-low reset |
| addr_i | input | 8 | Host I/O address (low byte) |
| iorq_n_i | input | 1 | Host I/O request, active low |
| rd_n_i | input | 1 | Host read strobe, active low |
| wr_n_i | input | 1 | Host write strobe, active low |
| hdata_i | input | 8 | Host data bus, incoming |
| hdata_o | output | 8 | Host data bus, outgoing |
| hdata_oe_o | output | 1 | Host data bus drive enable |
| fdata_i | input | 8 | Controller-side inverted data bus, incoming |
| fdata_o | output | 8 | Controller-side inverted data bus, outgoing |
| fdata_oe_o | output | 1 | Controller-side data bus drive enable |
| fdc_cs_n_o | output | 1 | Controller chip select, active low |
| intrq_i | input | 1 | Controller interrupt request |
| mode_i | input | 3 | Host-type jumpers |
| drv_sel_n_o | output | 4 | Drive selects A–D, active low |
| motor_o | output | 1 | Spindle motor enable |
| side_o | output | 1 | Head side |
| dden_n_o | output | 1 | Double density select, active low |
| int_o | output | 1 | Gated interrupt to host |
| fdc_clk_o | output | 1 | Divided clock to the controller |

## Verification
The assertions watch the combinational relationships on every cycle. They cover chip select only inside the controller window, data inversion in both directions, the two drive enables never overlapping, at most one drive selected, no interrupt without a request, an interrupt that drops after a clearing read, and a clock output that toggles every cycle. The bench scenarios show what depends on history. These are the offset drive-code mapping for every code, the inverted sense of the side and density bits, the set-then-clear sequence of the interrupt enable, and the jumper value frozen at reset release even after the jumpers later change.

// File: rtl/fdc_io_pkg.sv
package fdc_io_pkg;

  localparam logic [7:0] FDC_WIN_BASE = 8'hD8;  // four ports, low two bits pass to the controller
  localparam logic [7:0] PORT_DRIVE   = 8'hDC;
  localparam logic [7:0] PORT_SIDE    = 8'hDD;
  localparam logic [7:0] PORT_DENS    = 8'hDE;
  localparam logic [7:0] PORT_IRQ     = 8'hDF;
  localparam logic [7:0] PORT_MODE    = 8'h63;

  typedef struct packed {
    logic fdc_rd;
    logic fdc_wr;
    logic drv_wr;
    logic side_wr;
    logic dens_wr;
    logic irq_set;
    logic irq_clr;
    logic mode_rd;
  } io_dec_t;

  function automatic logic [7:0] flip_bus(input logic [7:0] v);
    return ~v;
  endfunction

  function automatic logic in_fdc_window(input logic [7:0] a);
    return a[7:2] == FDC_WIN_BASE[7:2];
  endfunction

endpackage

// File: rtl/fdc_io_decode.sv
module fdc_io_decode
  import fdc_io_pkg::*;
(
  input  logic [7:0] addr_i,
  input  logic       iorq_n_i,
  input  logic       rd_n_i,
  input  logic       wr_n_i,
  output io_dec_t    dec_o
);

  logic io_rd, io_wr;

  assign io_rd = !iorq_n_i && !rd_n_i;
  assign io_wr = !iorq_n_i && !wr_n_i;

  always_comb begin
    dec_o         = '0;
    dec_o.fdc_rd  = io_rd && in_fdc_window(addr_i);
    dec_o.fdc_wr  = io_wr && in_fdc_window(addr_i);
    dec_o.drv_wr  = io_wr && (addr_i == PORT_DRIVE);
    dec_o.side_wr = io_wr && (addr_i == PORT_SIDE);
    dec_o.dens_wr = io_wr && (addr_i == PORT_DENS);
    dec_o.irq_set = io_wr && (addr_i == PORT_IRQ);
    dec_o.irq_clr = io_rd && (addr_i == PORT_IRQ);
    dec_o.mode_rd = io_rd && (addr_i == PORT_MODE);
  end

endmodule

// File: rtl/fdc_io_ctrl.sv
module fdc_io_ctrl
  import fdc_io_pkg::*;
#(
  parameter int DRIVES = 4,
  parameter int MODE_W = 3,
  localparam int SEL_W = $clog2(DRIVES),
  localparam int CODE_W = SEL_W + 1
)(
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  io_dec_t           dec_i,
  input  logic [CODE_W-1:0] wcode_i,
  input  logic              wbit7_i,
  input  logic              wbit0_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              intrq_i,
  output logic [DRIVES-1:0] drv_sel_n_o,
  output logic              motor_o,
  output logic              side_o,
  output logic              dden_n_o,
  output logic              int_o,
  output logic              int_en_o,
  output logic [MODE_W-1:0] mode_q_o
);

  logic [CODE_W-1:0] code_q;
  logic              motor_q, side_q, dden_n_q, int_en_q;
  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      code_q   <= '0;
      motor_q  <= 1'b0;
      side_q   <= 1'b0;
      dden_n_q <= 1'b1;
      int_en_q <= 1'b0;
    end else begin
      if (dec_i.drv_wr) begin
        code_q  <= wcode_i;
        motor_q <= wbit7_i;
      end
      if (dec_i.side_wr) side_q   <= !wbit0_i;
      if (dec_i.dens_wr) dden_n_q <= wbit0_i;
      if (dec_i.irq_set)      int_en_q <= 1'b1;
      else if (dec_i.irq_clr) int_en_q <= 1'b0;
    end
  end

  // jumpers follow the pins while reset is held, frozen at release
  always_ff @(posedge clk_i) begin
    if (!rst_n_i) mode_q <= mode_i;
  end

  // offset code: top bit set selects drive given by the lower bits
  for (genvar g = 0; g < DRIVES; g++) begin : g_drv
    assign drv_sel_n_o[g] = !(code_q[CODE_W-1] && (code_q[SEL_W-1:0] == SEL_W'(g)));
  end

  assign motor_o  = motor_q;
  assign side_o   = side_q;
  assign dden_n_o = dden_n_q;
  assign int_en_o = int_en_q;
  assign int_o    = intrq_i && int_en_q;
  assign mode_q_o = mode_q;

endmodule

// File: rtl/fdc_io_clkdiv.sv
module fdc_io_clkdiv #(
  parameter int DIV_LOG2 = 1
)(
  input  logic clk_i,
  input  logic rst_n_i,
  output logic clk_o
);

  logic [DIV_LOG2-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) cnt_q <= '0;
    else          cnt_q <= cnt_q + 1'b1;
  end

  assign clk_o = cnt_q[DIV_LOG2-1];

endmodule

// File: rtl/fdc_io_regs.sv
module fdc_io_regs
  import fdc_io_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MODE_W   = 3,
  parameter int DRIVES   = 4,
  parameter int DIV_LOG2 = 1,
  localparam int CODE_W  = $clog2(DRIVES) + 1
)(
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [7:0]        addr_i,
  input  logic              iorq_n_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic [DATA_W-1:0] hdata_i,
  output logic [DATA_W-1:0] hdata_o,
  output logic              hdata_oe_o,
  input  logic [DATA_W-1:0] fdata_i,
  output logic [DATA_W-1:0] fdata_o,
  output logic              fdata_oe_o,
  output logic              fdc_cs_n_o,
  input  logic              intrq_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [DRIVES-1:0] drv_sel_n_o,
  output logic              motor_o,
  output logic              side_o,
  output logic              dden_n_o,
  output logic              int_o,
  output logic              fdc_clk_o
);

  io_dec_t           dec;
  logic              int_en;
  logic [MODE_W-1:0] mode_q;
  logic              fdc_rd_ev, fdc_wr_ev, irq_clr_ev, mode_rd_ev;

  fdc_io_decode u_dec (
    .addr_i   (addr_i),
    .iorq_n_i (iorq_n_i),
    .rd_n_i   (rd_n_i),
    .wr_n_i   (wr_n_i),
    .dec_o    (dec)
  );

  fdc_io_ctrl #(.DRIVES(DRIVES), .MODE_W(MODE_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .dec_i       (dec),
    .wcode_i     (hdata_i[CODE_W-1:0]),
    .wbit7_i     (hdata_i[DATA_W-1]),
    .wbit0_i     (hdata_i[0]),
    .mode_i      (mode_i),
    .intrq_i     (intrq_i),
    .drv_sel_n_o (drv_sel_n_o),
    .motor_o     (motor_o),
    .side_o      (side_o),
    .dden_n_o    (dden_n_o),
    .int_o       (int_o),
    .int_en_o    (int_en),
    .mode_q_o    (mode_q)
  );

  fdc_io_clkdiv #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .clk_o   (fdc_clk_o)
  );

  assign fdc_rd_ev  = dec.fdc_rd;
  assign fdc_wr_ev  = dec.fdc_wr;
  assign irq_clr_ev = dec.irq_clr;
  assign mode_rd_ev = dec.mode_rd;

  assign fdc_cs_n_o = !(fdc_rd_ev || fdc_wr_ev);
  assign fdata_o    = flip_bus(hdata_i);
  assign fdata_oe_o = fdc_wr_ev;
  assign hdata_oe_o = fdc_rd_ev || mode_rd_ev;

  always_comb begin
    hdata_o = '0;
    if (fdc_rd_ev)       hdata_o = flip_bus(fdata_i);
    else if (mode_rd_ev) hdata_o = {{(DATA_W-MODE_W){1'b0}}, mode_q};
  end

endmodule

// File: rtl/fdc_io_regs_chk.sv
module fdc_io_regs_chk (
  input logic       clk_i,
  input logic       rst_n_i,
  input logic [7:0] addr_i,
  input logic       iorq_n_i,
  input logic [7:0] hdata_i,
  input logic [7:0] hdata_o,
  input logic       hdata_oe_o,
  input logic [7:0] fdata_i,
  input logic [7:0] fdata_o,
  input logic       fdata_oe_o,
  input logic       fdc_cs_n_o,
  input logic       intrq_i,
  input logic [3:0] drv_sel_n_o,
  input logic       int_o,
  input logic       fdc_clk_o,
  input logic       fdc_rd_ev,
  input logic       irq_clr_ev
);

  logic [1:0] run_cnt;
  always_ff @(posedge clk_i) begin
    if (!rst_n_i) run_cnt <= '0;
    else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
  end

  p_cs_window_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !fdc_cs_n_o |-> (!iorq_n_i && addr_i[7:2] == 6'h36));

  p_wr_invert_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    fdata_oe_o |-> (fdata_o == ~hdata_i));

  p_rd_invert_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    fdc_rd_ev |-> (hdata_oe_o && hdata_o == ~fdata_i));

  p_one_drive_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $onehot0(~drv_sel_n_o));

  p_int_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    int_o |-> intrq_i);

  p_int_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    irq_clr_ev |=> !int_o);

  p_clk_toggle_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (run_cnt >= 2'd2) |-> (fdc_clk_o != $past(fdc_clk_o)));

  p_oe_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !(hdata_oe_o && fdata_oe_o));

  p_fdc_oe_cs_r12: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    fdata_oe_o |-> !fdc_cs_n_o);

endmodule

bind fdc_io_regs fdc_io_regs_chk u_chk (
  .clk_i       (clk_i),
  .rst_n_i     (rst_n_i),
  .addr_i      (addr_i),
  .iorq_n_i    (iorq_n_i),
  .hdata_i     (hdata_i),
  .hdata_o     (hdata_o),
  .hdata_oe_o  (hdata_oe_o),
  .fdata_i     (fdata_i),
  .fdata_o     (fdata_o),
  .fdata_oe_o  (fdata_oe_o),
  .fdc_cs_n_o  (fdc_cs_n_o),
  .intrq_i     (intrq_i),
  .drv_sel_n_o (drv_sel_n_o),
  .int_o       (int_o),
  .fdc_clk_o   (fdc_clk_o),
  .fdc_rd_ev   (fdc_rd_ev),
  .irq_clr_ev  (irq_clr_ev)
);

// File: tb/sim_fdc_io_regs.sv
module sim_fdc_io_regs;

  typedef enum int {K_CSN, K_FDATA, K_HDATA, K_HOE, K_FOE, K_DRV, K_MOTOR,
                    K_SIDE, K_DDEN, K_INT, K_FCLK} kind_t;
  typedef struct {
    string      req;
    kind_t      kind;
    logic [7:0] exp;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] hdata_i = 8'h00, fdata_i = 8'h00;
  logic [7:0] hdata_o, fdata_o;
  logic       hdata_oe, fdata_oe, cs_n, intrq = 1'b0;
  logic [2:0] mode = 3'b101;
  logic [3:0] drv_n;
  logic       motor, side, dden_n, int_o, fclk;

  item_t q[$];
  int checks = 0, errors = 0, edges = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fdc_io_regs u0 (
    .clk_i(clk), .rst_n_i(rst_n), .addr_i(addr), .iorq_n_i(iorq_n),
    .rd_n_i(rd_n), .wr_n_i(wr_n), .hdata_i(hdata_i), .hdata_o(hdata_o),
    .hdata_oe_o(hdata_oe), .fdata_i(fdata_i), .fdata_o(fdata_o),
    .fdata_oe_o(fdata_oe), .fdc_cs_n_o(cs_n), .intrq_i(intrq), .mode_i(mode),
    .drv_sel_n_o(drv_n), .motor_o(motor), .side_o(side), .dden_n_o(dden_n),
    .int_o(int_o), .fdc_clk_o(fclk)
  );

  always @(posedge clk) if (rst_n) edges <= edges + 1;

  function automatic logic [7:0] actual(kind_t k);
    case (k)
      K_CSN:   return {7'b0, cs_n};
      K_FDATA: return fdata_o;
      K_HDATA: return hdata_o;
      K_HOE:   return {7'b0, hdata_oe};
      K_FOE:   return {7'b0, fdata_oe};
      K_DRV:   return {4'b0, drv_n};
      K_MOTOR: return {7'b0, motor};
      K_SIDE:  return {7'b0, side};
      K_DDEN:  return {7'b0, dden_n};
      K_INT:   return {7'b0, int_o};
      default: return {7'b0, fclk};
    endcase
  endfunction

  // monitor: every item queued during a cycle is compared at the next falling edge
  initial forever begin
    @(negedge clk);
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (actual(it.kind) !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind,
                 actual(it.kind), it.exp);
      end
    end
  end

  task automatic expect_v(string r, kind_t k, logic [7:0] e);
    item_t it;
    it.req = r; it.kind = k; it.exp = e;
    q.push_back(it);
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic bus_idle();
    iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    step();
  endtask

  task automatic io_wr(logic [7:0] a, logic [7:0] d);
    addr = a; hdata_i = d; iorq_n = 1'b0; wr_n = 1'b0; rd_n = 1'b1;
  endtask

  task automatic io_rd(logic [7:0] a);
    addr = a; iorq_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1;
  endtask

  function automatic logic [7:0] drive_exp(logic [2:0] c);
    case (c)
      3'd4: return 8'h0E;
      3'd5: return 8'h0D;
      3'd6: return 8'h0B;
      3'd7: return 8'h07;
      default: return 8'h0F;
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step(); step();
    // R10 reset state, also R9 clock held low
    expect_v("R10", K_DRV, 8'h0F);
    expect_v("R10", K_MOTOR, 8'h00);
    expect_v("R10", K_SIDE, 8'h00);
    expect_v("R10", K_DDEN, 8'h01);
    expect_v("R9", K_FCLK, 8'h00);
    step();
    rst_n = 1'b1;
    step();
    mode = 3'b010;  // change jumpers after release
    expect_v("R10", K_INT, 8'h00);
    step();

    // R9 toggling
    for (int i = 0; i < 4; i++) begin
      expect_v("R9", K_FCLK, 8'((edges + 1) & 1));
      step();
    end

    // R1 R2 R12 FDC writes
    foreach (q[i]) ;
    io_wr(8'hD9, 8'h5A);
    expect_v("R1", K_CSN, 8'h00);
    expect_v("R2", K_FDATA, 8'hA5);
    expect_v("R12", K_FOE, 8'h01);
    expect_v("R11", K_HOE, 8'h00);
    step(); bus_idle();
    io_wr(8'hDB, 8'hF0);
    expect_v("R2", K_FDATA, 8'h0F);
    expect_v("R1", K_CSN, 8'h00);
    step(); bus_idle();
    expect_v("R1", K_CSN, 8'h01);
    expect_v("R12", K_FOE, 8'h00);
    step();

    // R3 FDC reads
    fdata_i = 8'h3C;
    io_rd(8'hD8);
    expect_v("R3", K_HDATA, 8'hC3);
    expect_v("R3", K_HOE, 8'h01);
    expect_v("R1", K_CSN, 8'h00);
    expect_v("R12", K_FOE, 8'h00);
    step(); bus_idle();
    fdata_i = 8'h01;
    io_rd(8'hDA);
    expect_v("R3", K_HDATA, 8'hFE);
    step(); bus_idle();
    // R1 near-miss address
    io_rd(8'hD7);
    expect_v("R1", K_CSN, 8'h01);
    expect_v("R11", K_HOE, 8'h00);
    step(); bus_idle();

    // R4 every drive code, motor follows bit 7
    for (int c = 0; c < 8; c++) begin
      io_wr(8'hDC, {c[0], 4'b0000, c[2:0]});
      step(); bus_idle();
      expect_v("R4", K_DRV, drive_exp(c[2:0]));
      expect_v("R4", K_MOTOR, {7'b0, c[0]});
      step();
    end

    // R5 side, R6 density
    io_wr(8'hDD, 8'h00); step(); bus_idle();
    expect_v("R5", K_SIDE, 8'h01); step();
    io_wr(8'hDD, 8'h01); step(); bus_idle();
    expect_v("R5", K_SIDE, 8'h00); step();
    io_wr(8'hDE, 8'h00); step(); bus_idle();
    expect_v("R6", K_DDEN, 8'h00); step();
    io_wr(8'hDE, 8'hFF); step(); bus_idle();
    expect_v("R6", K_DDEN, 8'h01); step();

    // R11 reads of write-only ports leave host bus undriven
    io_rd(8'hDC); expect_v("R11", K_HOE, 8'h00); step(); bus_idle();
    io_rd(8'hDE); expect_v("R11", K_HOE, 8'h00); step(); bus_idle();

    // R7 interrupt gating
    intrq = 1'b1; step();
    expect_v("R7", K_INT, 8'h00); step();
    io_wr(8'hDF, 8'h00); step(); bus_idle();
    expect_v("R7", K_INT, 8'h01); step();
    intrq = 1'b0; step();
    expect_v("R7", K_INT, 8'h00); step();
    intrq = 1'b1;
    io_rd(8'hDF); expect_v("R11", K_HOE, 8'h00); step(); bus_idle();
    expect_v("R7", K_INT, 8'h00); step();
    intrq = 1'b0;

    // R8 mode read-back: value at reset release, not current pins
    io_rd(8'h63);
    expect_v("R8", K_HDATA, 8'h05);
    expect_v("R11", K_HOE, 8'h01);
    expect_v("R1", K_CSN, 8'h01);
    step(); bus_idle();

    // R10 a second reset restores defaults
    rst_n = 1'b0; step(); step();
    expect_v("R10", K_DRV, 8'h0F);
    expect_v("R10", K_MOTOR, 8'h00);
    expect_v("R10", K_DDEN, 8'h01);
    expect_v("R10", K_SIDE, 8'h00);
    step();
    rst_n = 1'b1; step();
    intrq = 1'b1;
    expect_v("R10", K_INT, 8'h00);
    step(); step();

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule